// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This block watches a free-running 16-bit timer value and compares it on every clock with a 16-bit compare value loaded by software. When the two become equal, the block carries out the action that a 4-bit mode field selects. It can drive an output pin high, drive it low, leave the pin alone, or raise a special event. Every one of these actions also sets an interrupt flag, which software clears with a strobe.

The special event emits two single-cycle strobes on the same clock. One tells the external timer to clear both of its bytes. The other starts an analog-to-digital conversion. The timer-clear strobe is separate from any overflow path, so a clear made this way never appears as a timer overflow. The pin level is held in a set/reset latch. On entry to a pin mode, the latch is preset to the level opposite to the one that a match produces.

Mode codes: 1000 = set the pin on a match, 1001 = clear the pin on a match, 1010 = flag only, 1011 = special event. Any code whose upper two bits are not 10 disables the unit. A match is taken only on the first cycle of an equality, so a timer that stays at the compare value triggers one action.

Top module: `cmp_match_unit`

## Requirements
- R1: Every cycle, the timer input is compared with the compare input over all 16 bits. A difference in any single bit counts as no match.
- R2: In modes 1000 to 1011, the first cycle of equality sets flag_o, and flag_o reads 1 from the following clock cycle.
- R3: A match in mode 1000 drives pin_o to 1 on the next cycle. A match in mode 1001 drives pin_o to 0 on the next cycle.
- R4: On the cycle after mode_i changes to 1000, pin_o is 0. On the cycle after mode_i changes to 1001, pin_o is 1. On the cycle in which mode_i changes, no match action is taken, even if the inputs are equal.
- R5: A match in mode 1011 produces tmr_clr_o and adc_start_o together, high for exactly one cycle, on the next cycle. pin_o does not change.
- R6: A match in mode 1010 sets only the flag. pin_o keeps its level and neither strobe fires.
- R7: While the timer stays equal to the compare value, no further action occurs. If the flag is cleared during the equality, it stays clear.
- R8: flag_clr_i clears flag_o on the next cycle. If a match and a clear occur in the same cycle, the flag ends up set.
- R9: When the upper two bits of mode_i are not 10, a match has no effect. The flag stays clear, no strobe fires and pin_o holds its level.
- R10: After reset, pin_o, flag_o, tmr_clr_o and adc_start_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Match action select |
| cmp_val_i | input | 16 | Compare value |
| timer_i | input | 16 | Timer value |
| flag_clr_i | input | 1 | Interrupt flag clear strobe |
| pin_o | output | 1 | Output pin level |
| flag_o | output | 1 | Interrupt flag |
| tmr_clr_o | output | 1 | Timer clear strobe |
| adc_start_o | output | 1 | Conversion start strobe |

## Verification
Some properties are checked on every cycle:
- Each flag rise has a match event behind it.
- Every match event leaves the flag set.
- The two strobes are always coincident, last one cycle, and follow only special event matches.
- The pin moves only after a match or a mode change.

Only the bench scenarios can show the rest:
- The correct pin level for each mode.
- Preset on mode entry.
- Suppression of repeated action on a held equality.
- Set-over-clear priority.
- Inertness of the disabled codes.

The bench shows these by comparing against a reference model on every clock.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int TMR_W  = 16;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_PIN_SET  = 4'b1000,
    MODE_PIN_CLR  = 4'b1001,
    MODE_FLAG     = 4'b1010,
    MODE_SPECIAL  = 4'b1011
  } cmp_mode_e;

  function automatic logic is_active_mode(input logic [MODE_W-1:0] m);
    return m[MODE_W-1:MODE_W-2] == 2'b10;
  endfunction

  function automatic logic values_equal(input logic [TMR_W-1:0] a,
                                        input logic [TMR_W-1:0] b);
    return (a ^ b) == '0;
  endfunction
endpackage

// File: rtl/cmp_edge_detect.sv
module cmp_edge_detect
  import cmp_pkg::*;
#(
  parameter int W  = TMR_W,
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode_i,
  input  logic [W-1:0]  cmp_val_i,
  input  logic [W-1:0]  timer_i,
  output logic          mode_chg_o,
  output logic          match_evt_o
);
  logic          eq_now;
  logic          eq_q;
  logic [MW-1:0] mode_q;

  assign eq_now     = values_equal(timer_i, cmp_val_i);
  assign mode_chg_o = mode_i != mode_q;
  assign match_evt_o = is_active_mode(mode_i) && eq_now && !eq_q && !mode_chg_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q   <= 1'b0;
      mode_q <= '0;
    end else begin
      eq_q   <= eq_now;
      mode_q <= mode_i;
    end
  end
endmodule

// File: rtl/cmp_pin_latch.sv
module cmp_pin_latch
  import cmp_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode_i,
  input  logic          mode_chg_i,
  input  logic          match_evt_i,
  output logic          pin_o
);
  logic preset_lo, preset_hi, hit_set, hit_clr;

  assign preset_lo = mode_chg_i && (mode_i == MODE_PIN_SET);
  assign preset_hi = mode_chg_i && (mode_i == MODE_PIN_CLR);
  assign hit_set   = match_evt_i && (mode_i == MODE_PIN_SET);
  assign hit_clr   = match_evt_i && (mode_i == MODE_PIN_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pin_o <= 1'b0;
    else if (preset_hi || hit_set) pin_o <= 1'b1;
    else if (preset_lo || hit_clr) pin_o <= 1'b0;
  end
endmodule

// File: rtl/cmp_event_ctrl.sv
module cmp_event_ctrl
  import cmp_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode_i,
  input  logic          match_evt_i,
  input  logic          flag_clr_i,
  output logic          flag_o,
  output logic          special_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o    <= 1'b0;
      special_o <= 1'b0;
    end else begin
      if (match_evt_i)     flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
      special_o <= match_evt_i && (mode_i == MODE_SPECIAL);
    end
  end
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TMR_W-1:0]  cmp_val_i,
  input  logic [TMR_W-1:0]  timer_i,
  input  logic              flag_clr_i,
  output logic              pin_o,
  output logic              flag_o,
  output logic              tmr_clr_o,
  output logic              adc_start_o
);
  logic mode_chg;
  logic match_evt;
  logic special_pulse;

  cmp_edge_detect #(.W(TMR_W), .MW(MODE_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cmp_val_i(cmp_val_i),
    .timer_i(timer_i), .mode_chg_o(mode_chg), .match_evt_o(match_evt)
  );

  cmp_pin_latch #(.MW(MODE_W)) u_pin (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_chg_i(mode_chg),
    .match_evt_i(match_evt), .pin_o(pin_o)
  );

  cmp_event_ctrl #(.MW(MODE_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .match_evt_i(match_evt),
    .flag_clr_i(flag_clr_i), .flag_o(flag_o), .special_o(special_pulse)
  );

  assign tmr_clr_o   = special_pulse;
  assign adc_start_o = special_pulse;
endmodule

// File: rtl/cmp_match_chk.sv
module cmp_match_chk
  import cmp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_i,
  input logic              match_evt,
  input logic              mode_chg,
  input logic              pin_o,
  input logic              flag_o,
  input logic              tmr_clr_o,
  input logic              adc_start_o
);
  assert_flag_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(match_evt));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_o);

  assert_strobe_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr_o == adc_start_o);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr_o |=> !tmr_clr_o);

  assert_strobe_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_clr_o) |-> ($past(match_evt) && $past(mode_i) == MODE_SPECIAL));

  assert_pin_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(pin_o) |-> $past(match_evt || mode_chg));

  assert_no_act_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_active_mode(mode_i) |-> !match_evt);
endmodule

bind cmp_match_unit cmp_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .match_evt(match_evt),
  .mode_chg(mode_chg), .pin_o(pin_o), .flag_o(flag_o),
  .tmr_clr_o(tmr_clr_o), .adc_start_o(adc_start_o)
);

// File: tb/tb_cmp_match_unit.sv
module tb_cmp_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'h0;
  logic [15:0] cmpv = 16'h0;
  logic [15:0] tmr = 16'h0;
  logic        clr = 1'b0;
  logic pin, flag, tclr, astart;

  int checks = 0;
  int errors = 0;
  string req = "R10";

  // reference model state
  logic       m_pin, m_flag, m_pulse, m_eq;
  logic [3:0] m_mode;

  always #4 clk = ~clk;

  cmp_match_unit dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cmp_val_i(cmpv), .timer_i(tmr),
    .flag_clr_i(clr), .pin_o(pin), .flag_o(flag), .tmr_clr_o(tclr),
    .adc_start_o(astart)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pin = 0; m_flag = 0; m_pulse = 0; m_eq = 0; m_mode = 0;
    end else begin
      automatic bit eq = (tmr == cmpv);
      automatic bit on = (mode >= 4'd8) && (mode <= 4'd11);
      automatic bit fresh = (mode != m_mode);
      automatic bit fire = on && eq && !m_eq && !fresh;
      m_pulse = fire && (mode == 4'd11);
      if (fresh && mode == 4'd9)      m_pin = 1;
      else if (fresh && mode == 4'd8) m_pin = 0;
      else if (fire && mode == 4'd8)  m_pin = 1;
      else if (fire && mode == 4'd9)  m_pin = 0;
      if (fire) m_flag = 1; else if (clr) m_flag = 0;
      m_eq = eq; m_mode = mode;
    end
  end

  task automatic check1(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b @%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    check1("pin", pin, m_pin);
    check1("flag", flag, m_flag);
    check1("tmr_clr", tclr, m_pulse);
    check1("adc_start", astart, m_pulse);
  endtask

  // drive, then sample the result at the following falling edge
  task automatic step(logic [3:0] md, logic [15:0] cv, logic [15:0] tv, logic c);
    mode = md; cmpv = cv; tmr = tv; clr = c;
    @(negedge clk);
    cmp_all();
  endtask

  task automatic sweep(logic [3:0] md, logic [15:0] cv, int lo, int hi);
    for (int t = lo; t <= hi; t++) step(md, cv, 16'(t), 1'b0);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R10"; cmp_all();
    rst_n = 1'b1;
    @(negedge clk); cmp_all();

    // R4 preset low on entry, R3 set on match, R2 flag
    req = "R3"; sweep(4'd8, 16'd5, 0, 9);
    check1("R3 pin high after match", pin, 1'b1);
    // R8 clear flag
    req = "R8"; step(4'd8, 16'd5, 16'd9, 1'b1); step(4'd8, 16'd5, 16'd9, 1'b0);
    check1("R8 flag cleared", flag, 1'b0);
    // R7 held equality: flag cleared while equal stays clear
    req = "R7";
    step(4'd8, 16'd20, 16'd20, 1'b0);
    step(4'd8, 16'd20, 16'd20, 1'b1);
    for (int i = 0; i < 5; i++) step(4'd8, 16'd20, 16'd20, 1'b0);
    check1("R7 no re-fire", flag, 1'b0);

    // R4 preset high, R3 clear on match
    req = "R4"; step(4'd9, 16'd100, 16'd0, 1'b0);
    check1("R4 preset high", pin, 1'b1);
    req = "R3"; sweep(4'd9, 16'd100, 95, 103);
    check1("R3 pin low after match", pin, 1'b0);

    // R6 flag only
    req = "R6"; step(4'd10, 16'h1234, 16'h1230, 1'b1);
    sweep(4'd10, 16'h1234, 16'h1231, 16'h1238);
    check1("R6 pin unchanged", pin, 1'b0);

    // R5 special event
    req = "R5"; step(4'd11, 16'hBEEF, 16'h0000, 1'b1);
    sweep(4'd11, 16'hBEEF, 16'hBEEC, 16'hBEF2);
    step(4'd11, 16'hBEEF, 16'hBEEF, 1'b0);
    check1("R5 strobe on match", tclr, 1'b1);
    step(4'd11, 16'hBEEF, 16'hBEEF, 1'b0);
    check1("R5 strobe one cycle", tclr, 1'b0);

    // R8 simultaneous match and clear: set wins
    req = "R8"; step(4'd11, 16'h0040, 16'h0000, 1'b0);
    step(4'd11, 16'h0040, 16'h0040, 1'b1);
    check1("R8 set wins", flag, 1'b1);

    // R4 entry while equal: no action
    req = "R4"; step(4'd10, 16'h0007, 16'h0007, 1'b1);
    step(4'd8, 16'h0007, 16'h0007, 1'b0);
    step(4'd8, 16'h0007, 16'h0007, 1'b0);
    check1("R4 entry suppresses match", flag, 1'b0);
    check1("R4 pin preset low", pin, 1'b0);

    // R9 disabled codes
    req = "R9"; step(4'd9, 16'd3, 16'd0, 1'b0);
    step(4'd0, 16'd3, 16'd0, 1'b1);
    sweep(4'd0, 16'd3, 1, 5);
    sweep(4'd12, 16'd3, 1, 5);
    sweep(4'd3, 16'd3, 1, 5);
    check1("R9 no flag", flag, 1'b0);
    check1("R9 pin held", pin, 1'b1);

    // R1 single-bit differences never match
    req = "R1"; step(4'd10, 16'h8001, 16'h0000, 1'b1);
    for (int b = 0; b < 16; b++) step(4'd10, 16'h8001, 16'h8001 ^ (16'h1 << b), 1'b0);
    check1("R1 no partial match", flag, 1'b0);
    step(4'd10, 16'h8001, 16'h8001, 1'b0);
    check1("R1 full match", flag, 1'b1);

    // R2 mixed traffic against the model
    req = "R2";
    for (int i = 0; i < 600; i++) begin
      automatic logic [3:0] md = (i % 97 < 8) ? 4'($urandom_range(0, 15))
                                             : 4'(8 + (i / 97) % 4);
      step(md == 4'd0 ? 4'd8 : md, 16'd6, 16'($urandom_range(0, 12)),
           1'($urandom_range(0, 3) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule